// File: doc/BRIEF.md
# Flash Controller Interrupt Status Register

This block gathers the event strobes that a NAND-style flash controller's operation engine produces and latches each one into a fixed bit of a 32-bit status word. Completion, failure, timeout, protection, command-error, cache-sequence, reset-done and device-pin events each own a bit. Two event sources share bit 0: load failure and ECC error. The erase-done and program-done bits clear themselves when a new operation of the same kind starts. This lets the host tell a fresh completion from an old one without first clearing the bit.

The host reaches the block through a small register bus. Word 0 is the status word, and the host clears bits there by writing 1 to them. Word 1 is an enable word that masks which status bits drive the interrupt line. The interrupt output is registered and equals the OR of the status bits that are both set and enabled.

Top module: `flash_irq_status`

## Requirements
- R1: After a synchronous reset, the status word, the enable word, the read-data output and `irq_o` are all zero.
- R2: Bits 31:14 and bit 11 are reserved in both words. Writes do not change them and reads return 0 in those positions.
- R3: Each event strobe sets its own status bit: cache error 13, init done 12, device pin activity 10, unsupported command 9, protected block 8, other completion 7, erase done 6, program done 5, load done 4, erase fail 3, program fail 2, timeout 1. A set bit stays set until something clears it.
- R4: Status bit 0 is set by a load-failure strobe or by an ECC-error strobe.
- R5: A bus write to word 0 clears every status bit whose data bit is 1. Bits written with 0 keep their value.
- R6: When a set event and a host clear hit the same bit in the same cycle, the bit ends up set.
- R7: An erase-start strobe clears bit 6 and a program-start strobe clears bit 5. No other bit changes.
- R8: When the done event of an operation arrives in the same cycle as the start of the same kind of operation, the done bit ends up set.
- R9: A bus write to word 1 loads the enable word from the write data, with reserved positions forced to 0.
- R10: `irq_o` is 1 exactly when some bit is set in both the status word and the enable word. It follows those registers with no extra delay.
- R11: A read (`bus_en`=1, `bus_we`=0) returns the addressed word on `bus_rdata` in the next cycle. The value is the word as it stood before that clock edge. Addresses other than 0 and 1 return zero. When no read is made, `bus_rdata` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (0 status, 1 enable) |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data |
| ev_load_fail | input | 1 | Load failed |
| ev_ecc_err | input | 1 | ECC error |
| ev_timeout | input | 1 | Interrupt timeout |
| ev_prog_fail | input | 1 | Program failed |
| ev_erase_fail | input | 1 | Erase failed |
| ev_load_done | input | 1 | Load complete |
| ev_prog_done | input | 1 | Program complete |
| ev_erase_done | input | 1 | Erase complete |
| ev_misc_done | input | 1 | Copyback, pipeline, lock-range or erase-verify complete |
| ev_prot_blk | input | 1 | Program or erase aimed at a protected block |
| ev_bad_cmd | input | 1 | Unsupported command or broken sequence |
| ev_pin_act | input | 1 | Device interrupt pin activity |
| ev_init_done | input | 1 | Reset and auto-initialisation finished |
| ev_cache_err | input | 1 | Cache/pipelined sequence error |
| ev_erase_start | input | 1 | Erase operation starts |
| ev_prog_start | input | 1 | Program operation starts |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every event strobe is a clean one-cycle level sampled at the clock edge. They also assume that a host write to word 0 is the only clearing path besides the two start strobes. The clear check therefore holds only when the same bit's set event is absent, and the property states that condition explicitly. Bus addresses outside the two defined words are assumed harmless. The stimulus changes inputs one nanosecond after each rising edge, so strobes never straddle an edge. It drives both isolated events and deliberate same-cycle collisions of set, clear and auto-clear, keeping every access within the defined bus encoding.

// File: rtl/fisr_pkg.sv
package fisr_pkg;
  // Status bit positions (fixed: the host decodes them)
  localparam int B_LDFAIL  = 0;
  localparam int B_TMO     = 1;
  localparam int B_PGMFAIL = 2;
  localparam int B_ERSFAIL = 3;
  localparam int B_LDDONE  = 4;
  localparam int B_PGMDONE = 5;
  localparam int B_ERSDONE = 6;
  localparam int B_MISC    = 7;
  localparam int B_PROT    = 8;
  localparam int B_BADCMD  = 9;
  localparam int B_PIN     = 10;
  localparam int B_INIT    = 12;
  localparam int B_CACHE   = 13;
  // Implemented-bit mask: 13..12 and 10..0
  localparam logic [31:0] IMPL_MASK32 = 32'h0000_37FF;
  // Word addresses
  localparam int ADDR_STAT = 0;
  localparam int ADDR_ENA  = 1;
endpackage

// File: rtl/fisr_event_map.sv
module fisr_event_map
  import fisr_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             ev_load_fail,
  input  logic             ev_ecc_err,
  input  logic             ev_timeout,
  input  logic             ev_prog_fail,
  input  logic             ev_erase_fail,
  input  logic             ev_load_done,
  input  logic             ev_prog_done,
  input  logic             ev_erase_done,
  input  logic             ev_misc_done,
  input  logic             ev_prot_blk,
  input  logic             ev_bad_cmd,
  input  logic             ev_pin_act,
  input  logic             ev_init_done,
  input  logic             ev_cache_err,
  input  logic             ev_erase_start,
  input  logic             ev_prog_start,
  output logic [REG_W-1:0] set_vec,
  output logic [REG_W-1:0] auto_vec
);
  always_comb begin
    set_vec            = '0;
    set_vec[B_LDFAIL]  = ev_load_fail | ev_ecc_err;
    set_vec[B_TMO]     = ev_timeout;
    set_vec[B_PGMFAIL] = ev_prog_fail;
    set_vec[B_ERSFAIL] = ev_erase_fail;
    set_vec[B_LDDONE]  = ev_load_done;
    set_vec[B_PGMDONE] = ev_prog_done;
    set_vec[B_ERSDONE] = ev_erase_done;
    set_vec[B_MISC]    = ev_misc_done;
    set_vec[B_PROT]    = ev_prot_blk;
    set_vec[B_BADCMD]  = ev_bad_cmd;
    set_vec[B_PIN]     = ev_pin_act;
    set_vec[B_INIT]    = ev_init_done;
    set_vec[B_CACHE]   = ev_cache_err;
  end

  always_comb begin
    auto_vec            = '0;
    auto_vec[B_ERSDONE] = ev_erase_start;
    auto_vec[B_PGMDONE] = ev_prog_start;
  end
endmodule

// File: rtl/fisr_status.sv
module fisr_status #(
  parameter int               REG_W = 32,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  input  logic [REG_W-1:0] auto_i,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] status_d
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      // set beats host clear and auto-clear
      assign status_d[i] = set_i[i] | (status_q[i] & ~clr_i[i] & ~auto_i[i]);
      always_ff @(posedge clk) begin
        if (rst) status_q[i] <= 1'b0;
        else     status_q[i] <= status_d[i];
      end
    end else begin : g_rsv
      assign status_d[i] = 1'b0;
      assign status_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fisr_host_if.sv
module fisr_host_if
  import fisr_pkg::*;
#(
  parameter int               REG_W  = 32,
  parameter int               ADDR_W = 2,
  parameter logic [REG_W-1:0] IMPL   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  status_q,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  enable_q,
  output logic [REG_W-1:0]  enable_d,
  output logic [REG_W-1:0]  rdata_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ADDR_ENA);

  logic wr_stat, wr_ena, rd;

  assign wr_stat  = bus_en & bus_we & (bus_addr == A_STAT);
  assign wr_ena   = bus_en & bus_we & (bus_addr == A_ENA);
  assign rd       = bus_en & ~bus_we;
  assign clr_vec  = wr_stat ? (bus_wdata & IMPL) : '0;
  assign enable_d = wr_ena ? (bus_wdata & IMPL) : enable_q;

  always_ff @(posedge clk) begin
    if (rst) enable_q <= '0;
    else     enable_q <= enable_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      case (bus_addr)
        A_STAT:  rdata_q <= status_q;
        A_ENA:   rdata_q <= enable_q;
        default: rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import fisr_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_load_fail,
  input  logic              ev_ecc_err,
  input  logic              ev_timeout,
  input  logic              ev_prog_fail,
  input  logic              ev_erase_fail,
  input  logic              ev_load_done,
  input  logic              ev_prog_done,
  input  logic              ev_erase_done,
  input  logic              ev_misc_done,
  input  logic              ev_prot_blk,
  input  logic              ev_bad_cmd,
  input  logic              ev_pin_act,
  input  logic              ev_init_done,
  input  logic              ev_cache_err,
  input  logic              ev_erase_start,
  input  logic              ev_prog_start,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] IMPL = REG_W'(IMPL_MASK32);

  logic [REG_W-1:0] set_vec, auto_vec, clr_vec;
  logic [REG_W-1:0] status_q, status_d, enable_q, enable_d;

  fisr_event_map #(.REG_W(REG_W)) u_map (
    .ev_load_fail  (ev_load_fail),
    .ev_ecc_err    (ev_ecc_err),
    .ev_timeout    (ev_timeout),
    .ev_prog_fail  (ev_prog_fail),
    .ev_erase_fail (ev_erase_fail),
    .ev_load_done  (ev_load_done),
    .ev_prog_done  (ev_prog_done),
    .ev_erase_done (ev_erase_done),
    .ev_misc_done  (ev_misc_done),
    .ev_prot_blk   (ev_prot_blk),
    .ev_bad_cmd    (ev_bad_cmd),
    .ev_pin_act    (ev_pin_act),
    .ev_init_done  (ev_init_done),
    .ev_cache_err  (ev_cache_err),
    .ev_erase_start(ev_erase_start),
    .ev_prog_start (ev_prog_start),
    .set_vec       (set_vec),
    .auto_vec      (auto_vec)
  );

  fisr_status #(.REG_W(REG_W), .IMPL(IMPL)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .auto_i  (auto_vec),
    .status_q(status_q),
    .status_d(status_d)
  );

  fisr_host_if #(.REG_W(REG_W), .ADDR_W(ADDR_W), .IMPL(IMPL)) u_host (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .status_q (status_q),
    .clr_vec  (clr_vec),
    .enable_q (enable_q),
    .enable_d (enable_d),
    .rdata_q  (bus_rdata)
  );

  // Registered interrupt, computed from next-state so it lines up with the registers
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_d & enable_d);
  end
endmodule

// File: rtl/fisr_checker.sv
module fisr_checker
  import fisr_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              ev_load_done,
  input logic              ev_prot_blk,
  input logic              ev_erase_start,
  input logic              ev_erase_done,
  input logic [REG_W-1:0]  status,
  input logic [REG_W-1:0]  enable,
  input logic              irq_o
);
  localparam logic [REG_W-1:0] MASK = REG_W'(IMPL_MASK32);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status == '0 && enable == '0 && !irq_o && bus_rdata == '0)); // R1

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~MASK) == '0); // R2

  AST_PROT_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_prot_blk |=> status[B_PROT]); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(ADDR_STAT) && bus_wdata[B_LDDONE] && !ev_load_done)
      |=> !status[B_LDDONE]); // R5

  AST_ERASE_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
    (ev_erase_start && !ev_erase_done) |=> !status[B_ERSDONE]); // R7

  AST_DONE_BEATS_START: assert property (@(posedge clk) disable iff (rst)
    (ev_erase_start && ev_erase_done) |=> status[B_ERSDONE]); // R8

  AST_ENA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_addr == ADDR_W'(ADDR_ENA)) |=> enable == ($past(bus_wdata) & MASK)); // R9

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status & enable)); // R10
endmodule

bind flash_irq_status fisr_checker #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_en        (bus_en),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .ev_load_done  (ev_load_done),
  .ev_prot_blk   (ev_prot_blk),
  .ev_erase_start(ev_erase_start),
  .ev_erase_done (ev_erase_done),
  .status        (status_q),
  .enable        (enable_q),
  .irq_o         (irq_o)
);

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;
  localparam int W  = 32;
  localparam int AW = 2;
  localparam logic [31:0] IMPL = 32'h0000_37FF;

  logic clk = 0;
  always #5 clk = ~clk;

  logic          rst = 1;
  logic          bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [15:0]   ev = '0;  // bench event bundle, index -> see ev_bit()
  logic          irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  flash_irq_status #(.REG_W(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_load_fail(ev[0]), .ev_ecc_err(ev[1]), .ev_timeout(ev[2]),
    .ev_prog_fail(ev[3]), .ev_erase_fail(ev[4]), .ev_load_done(ev[5]),
    .ev_prog_done(ev[6]), .ev_erase_done(ev[7]), .ev_misc_done(ev[8]),
    .ev_prot_blk(ev[9]), .ev_bad_cmd(ev[10]), .ev_pin_act(ev[11]),
    .ev_init_done(ev[12]), .ev_cache_err(ev[13]),
    .ev_erase_start(ev[14]), .ev_prog_start(ev[15]),
    .irq_o(irq_o)
  );

  // Event index -> status bit, from R3/R4
  function automatic int ev_bit(int idx);
    if (idx < 2)  return 0;
    if (idx < 12) return idx - 1;
    return idx;
  endfunction

  // Behavioural reference model
  logic [31:0] m_st = '0, m_en = '0, m_rd = '0;
  always @(posedge clk) begin
    logic [31:0] setv, clrv, autov;
    if (rst) begin
      m_st = '0; m_en = '0; m_rd = '0;
    end else begin
      setv = '0;
      for (int i = 0; i < 14; i++) if (ev[i]) setv[ev_bit(i)] = 1'b1;
      autov = '0;
      if (ev[14]) autov[6] = 1'b1;
      if (ev[15]) autov[5] = 1'b1;
      clrv = (bus_en && bus_we && bus_addr == 0) ? bus_wdata & IMPL : '0;
      if (bus_en && !bus_we)
        m_rd = (bus_addr == 0) ? m_st : (bus_addr == 1) ? m_en : '0;
      if (bus_en && bus_we && bus_addr == 1) m_en = bus_wdata & IMPL;
      m_st = (setv | (m_st & ~clrv & ~autov)) & IMPL;
    end
  end

  // Per-clock comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (irq_o !== (|(m_st & m_en))) begin
        bad++;
        $display("FAIL R10 irq: got %0b exp %0b", irq_o, |(m_st & m_en));
      end
      total++;
      if (bus_rdata !== m_rd) begin
        bad++;
        $display("FAIL R11 rdata: got %h exp %h", bus_rdata, m_rd);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    step();
    bus_en = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    step();
    bus_en = 0;
    #4;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] v);
    ev = v; step(); ev = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 0;
    #4;
    check("R1 irq reset", {31'b0, irq_o}, 32'h0);
    check("R1 rdata reset", bus_rdata, 32'h0);
    step();
    rd_chk(0, 32'h0, "R1 status reset");
    rd_chk(1, 32'h0, "R1 enable reset");

    // R2 / R9: reserved bits dropped on enable write
    wr(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h0000_37FF, "R2 R9 enable mask");
    wr(1, 32'h0);

    // R3 / R4: every event to its bit, then write-1 clear
    for (int i = 0; i < 14; i++) begin
      pulse(16'(1 << i));
      rd_chk(0, 32'(1) << ev_bit(i), (i < 2) ? "R4 shared bit0" : "R3 event map");
      wr(0, 32'hFFFF_FFFF);
      rd_chk(0, 32'h0, "R5 clear all");
    end

    // R5: write 0 keeps, write 1 clears only selected
    pulse(16'h0220);               // load done (4) + prot (8)
    wr(0, 32'h0);
    rd_chk(0, 32'h0000_0110, "R5 write zero keeps");
    wr(0, 32'h0000_0010);
    rd_chk(0, 32'h0000_0100, "R5 selective clear");

    // R6: set and clear same cycle
    ev = 16'h0200; bus_en = 1; bus_we = 1; bus_addr = 0; bus_wdata = 32'h100;
    step();
    ev = '0; bus_en = 0; bus_we = 0; bus_wdata = '0;
    rd_chk(0, 32'h0000_0100, "R6 set wins");
    wr(0, 32'hFFFF_FFFF);

    // R7: auto-clear at start
    pulse(16'h00D0);               // erase done, prog done, erase fail
    rd_chk(0, 32'h0000_0068, "R7 setup");
    pulse(16'h4000);
    rd_chk(0, 32'h0000_0028, "R7 erase start clears bit6");
    pulse(16'h8000);
    rd_chk(0, 32'h0000_0008, "R7 prog start clears bit5");

    // R8: done and start in same cycle
    pulse(16'h4080);
    rd_chk(0, 32'h0000_0048, "R8 erase done beats start");
    pulse(16'h8040);
    rd_chk(0, 32'h0000_0068, "R8 prog done beats start");

    // R10: masking
    wr(1, 32'h0000_0001);
    #4 check("R10 masked irq low", {31'b0, irq_o}, 32'h0);
    step();
    wr(1, 32'h0000_0008);
    #4 check("R10 enabled irq high", {31'b0, irq_o}, 32'h1);
    step();
    wr(0, 32'h0000_0008);
    #4 check("R10 irq drops after clear", {31'b0, irq_o}, 32'h0);
    step();

    // R11: unmapped address reads zero
    rd_chk(2, 32'h0, "R11 unmapped");
    rd_chk(3, 32'h0, "R11 unmapped");
    rd_chk(0, 32'h0000_0060, "R11 status read");

    repeat (2) step();
    finish_run();
  end
endmodule